// File: doc/BRIEF.md
# Floating-point minimum/maximum unit

This block takes two IEEE 754 binary operands and returns the smaller or the larger one, as chosen by a single control bit. The result and five exception flags are captured in one output register, so they appear one clock after the operands. Rounding never applies, because the result is always one of the operand bit patterns or a fixed quiet NaN.

The ordering is found directly from the fields, with no subtraction. Sign decides first, then the biased exponent, then the significand. A lone NaN operand is suppressed, and the other operand passes through unchanged. Two NaN operands give the canonical quiet NaN. Any signalling NaN at the input raises the invalid-operation flag, even when the NaN itself is suppressed. The exponent and significand widths are parameters. The defaults give the 32-bit format.

Top module: `fp_minmax`

## Requirements
- R1: `op_max_i` = 0 selects the minimum and 1 selects the maximum. `res_o` and `flags_o` show the result for the inputs present at a rising clock edge after that edge. While `rst_ni` is low, both outputs read 0.
- R2: If exactly one operand is a NaN, `res_o` is the other operand, identical bit for bit. A NaN has an all-ones exponent and a non-zero significand.
- R3: If both operands are NaN, `res_o` is the canonical quiet NaN. This has sign 0, an all-ones exponent, the significand MSB set and all other bits 0. In the default format it is 0x7FC00000.
- R4: `flags_o[4]` (invalid) is 1 exactly when at least one operand is a signalling NaN. A signalling NaN has an all-ones exponent, a significand MSB of 0 and a non-zero significand.
- R5: `flags_o[3]` (divide by zero), `flags_o[2]` (overflow), `flags_o[1]` (underflow) and `flags_o[0]` (inexact) are always 0.
- R6: If neither operand is NaN and the signs differ, the operand with the sign bit 0 is returned for the maximum and the operand with sign bit 1 for the minimum. So -0 is below +0.
- R7: If the operands have the same sign and different exponents, ordering follows the magnitude implied by the exponent. A larger exponent is larger for positive operands and smaller for negative ones.
- R8: If the operands have the same sign and the same exponent, the significand decides in the same way, including for subnormals. Identical operands return that same pattern.
- R9: An infinity whose sign bit equals `op_max_i` yields the other operand. An infinity of the opposite sign is returned itself.
- R10: When neither operand is NaN, `res_o` equals `a_i` or `b_i` exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_max_i | input | 1 | 0 = minimum, 1 = maximum |
| a_i | input | 1+EXP_W+MAN_W | Operand a |
| b_i | input | 1+EXP_W+MAN_W | Operand b |
| res_o | output | 1+EXP_W+MAN_W | Selected result, registered |
| flags_o | output | 5 | {invalid, div-zero, overflow, underflow, inexact}, registered |

## Verification
NaN suppression and invalid-flag generation act in the same cycle when a signalling NaN is paired with an ordinary number. The number must come out unchanged while the invalid flag rises. Directed cases pair positive and negative signalling NaNs with finite values, infinities and zeros. Random cases draw operands from a pool that mixes these patterns. Each result is judged against a bench model that orders values through a monotone integer key, and the flag vector is judged against a separate signalling-NaN test on the raw fields.

// File: rtl/fp_minmax_pkg.sv
package fp_minmax_pkg;
  localparam int NUM_FLAGS = 5;
  localparam int FLAG_NV   = 4;
  localparam int FLAG_DZ   = 3;
  localparam int FLAG_OF   = 2;
  localparam int FLAG_UF   = 1;
  localparam int FLAG_NX   = 0;

  typedef struct packed {
    logic is_nan;
    logic is_snan;
  } fp_class_t;
endpackage

// File: rtl/fp_minmax_classify.sv
module fp_minmax_classify #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0]     op_i,
  output fp_minmax_pkg::fp_class_t cls_o
);
  localparam int W = 1 + EXP_W + MAN_W;

  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;
  logic             exp_ones;
  logic             man_nz;

  assign exp_f    = op_i[W-2 -: EXP_W];
  assign man_f    = op_i[MAN_W-1:0];
  assign exp_ones = &exp_f;
  assign man_nz   = |man_f;

  assign cls_o.is_nan  = exp_ones && man_nz;
  assign cls_o.is_snan = exp_ones && man_nz && !man_f[MAN_W-1];
endmodule

// File: rtl/fp_minmax_order.sv
module fp_minmax_order #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] a_i,
  input  logic [EXP_W+MAN_W:0] b_i,
  input  logic                 op_max_i,
  output logic                 pick_b_o
);
  localparam int W = 1 + EXP_W + MAN_W;

  logic sgn_a, sgn_b, exp_gt, exp_eq, man_gt;

  assign sgn_a  = a_i[W-1];
  assign sgn_b  = b_i[W-1];
  assign exp_gt = a_i[W-2 -: EXP_W] >  b_i[W-2 -: EXP_W];
  assign exp_eq = a_i[W-2 -: EXP_W] == b_i[W-2 -: EXP_W];
  assign man_gt = a_i[MAN_W-1:0] > b_i[MAN_W-1:0];

  // sign first, then exponent, then significand; sign and op flip the sense
  always_comb begin
    if (sgn_a != sgn_b)  pick_b_o = (sgn_a == op_max_i);
    else if (!exp_eq)    pick_b_o = exp_gt ^ sgn_a ^ op_max_i;
    else                 pick_b_o = man_gt ^ sgn_a ^ op_max_i;
  end
endmodule

// File: rtl/fp_minmax_select.sv
module fp_minmax_select #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0]                  a_i,
  input  logic [EXP_W+MAN_W:0]                  b_i,
  input  fp_minmax_pkg::fp_class_t              cls_a_i,
  input  fp_minmax_pkg::fp_class_t              cls_b_i,
  input  logic                                  pick_b_i,
  output logic [EXP_W+MAN_W:0]                  res_o,
  output logic [fp_minmax_pkg::NUM_FLAGS-1:0]   flags_o
);
  import fp_minmax_pkg::*;

  localparam int W = 1 + EXP_W + MAN_W;
  localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  always_comb begin
    if (cls_a_i.is_nan && cls_b_i.is_nan) res_o = QNAN;
    else if (cls_a_i.is_nan)              res_o = b_i;
    else if (cls_b_i.is_nan)              res_o = a_i;
    else if (pick_b_i)                    res_o = b_i;
    else                                  res_o = a_i;
  end

  always_comb begin
    flags_o          = '0;
    flags_o[FLAG_NV] = cls_a_i.is_snan | cls_b_i.is_snan;
  end
endmodule

// File: rtl/fp_minmax.sv
module fp_minmax #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   op_max_i,
  input  logic [EXP_W+MAN_W:0]   a_i,
  input  logic [EXP_W+MAN_W:0]   b_i,
  output logic [EXP_W+MAN_W:0]   res_o,
  output logic [4:0]             flags_o
);
  import fp_minmax_pkg::*;

  localparam int W = 1 + EXP_W + MAN_W;

  logic [W-1:0]         opnd [2];
  fp_class_t            cls  [2];
  logic                 pick_b;
  logic [W-1:0]         res_d;
  logic [NUM_FLAGS-1:0] flags_d;

  assign opnd[0] = a_i;
  assign opnd[1] = b_i;

  for (genvar i = 0; i < 2; i++) begin : g_cls
    fp_minmax_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
      .op_i  (opnd[i]),
      .cls_o (cls[i])
    );
  end

  fp_minmax_order #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_order (
    .a_i      (a_i),
    .b_i      (b_i),
    .op_max_i (op_max_i),
    .pick_b_o (pick_b)
  );

  fp_minmax_select #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_sel (
    .a_i      (a_i),
    .b_i      (b_i),
    .cls_a_i  (cls[0]),
    .cls_b_i  (cls[1]),
    .pick_b_i (pick_b),
    .res_o    (res_d),
    .flags_o  (flags_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o   <= '0;
      flags_o <= '0;
    end else begin
      res_o   <= res_d;
      flags_o <= flags_d;
    end
  end
endmodule

// File: rtl/fp_minmax_chk.sv
module fp_minmax_chk #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 op_max_i,
  input logic [EXP_W+MAN_W:0] a_i,
  input logic [EXP_W+MAN_W:0] b_i,
  input logic [EXP_W+MAN_W:0] res_o,
  input logic [4:0]           flags_o
);
  localparam int W = 1 + EXP_W + MAN_W;

  logic primed_q;
  logic a_nan, b_nan, a_snan, b_snan, res_nan;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) primed_q <= 1'b0;
    else         primed_q <= 1'b1;
  end

  assign a_nan   = (a_i[W-2 -: EXP_W] == {EXP_W{1'b1}}) && (a_i[MAN_W-1:0] != '0);
  assign b_nan   = (b_i[W-2 -: EXP_W] == {EXP_W{1'b1}}) && (b_i[MAN_W-1:0] != '0);
  assign a_snan  = a_nan && (a_i[MAN_W-1] == 1'b0);
  assign b_snan  = b_nan && (b_i[MAN_W-1] == 1'b0);
  assign res_nan = (res_o[W-2 -: EXP_W] == {EXP_W{1'b1}}) && (res_o[MAN_W-1:0] != '0);

  AST_INVALID_ON_SNAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed_q |-> (flags_o[4] == ($past(a_snan) || $past(b_snan)))); // R4
  AST_NO_OTHER_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[3:0] == 4'b0000); // R5
  AST_LONE_NAN_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed_q && $past(a_nan != b_nan)) |-> (res_o == ($past(a_nan) ? $past(b_i) : $past(a_i)))); // R2
  AST_BOTH_NAN_GIVES_NAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed_q && $past(a_nan && b_nan)) |-> (res_nan && !res_o[W-1])); // R3
  AST_RESULT_IS_OPERAND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed_q && $past(!a_nan && !b_nan)) |-> (res_o == $past(a_i) || res_o == $past(b_i))); // R10
  AST_SIGN_DECIDES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed_q && $past(!a_nan && !b_nan && (a_i[W-1] != b_i[W-1]))) |-> (res_o[W-1] == !$past(op_max_i))); // R6
endmodule

bind fp_minmax fp_minmax_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (.*);

// File: tb/fp_minmax_tb.sv
module fp_minmax_tb_top;
  localparam int EW = 8;
  localparam int MW = 23;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_max = 1'b0;
  logic [31:0] a = '0, b = '0;
  logic [31:0] res;
  logic [4:0]  flags;
  int          n_checks = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  fp_minmax #(.EXP_W(EW), .MAN_W(MW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .op_max_i(op_max),
    .a_i(a), .b_i(b), .res_o(res), .flags_o(flags)
  );

  function automatic bit is_nan(input logic [31:0] v);
    return (v[30:23] == 8'hFF) && (v[22:0] != 0);
  endfunction

  function automatic bit is_snan(input logic [31:0] v);
    return is_nan(v) && !v[22];
  endfunction

  // monotone integer key: larger key means larger value, -0 below +0
  function automatic logic [31:0] okey(input logic [31:0] v);
    return v[31] ? ~v : (v | 32'h8000_0000);
  endfunction

  function automatic logic [31:0] ref_res(input logic [31:0] x, input logic [31:0] y, input logic mx);
    if (is_nan(x) && is_nan(y)) return 32'h7FC0_0000;
    if (is_nan(x)) return y;
    if (is_nan(y)) return x;
    if (mx) return (okey(y) > okey(x)) ? y : x;
    return (okey(y) < okey(x)) ? y : x;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] x, input logic [31:0] y, input logic mx, input string req);
    @(negedge clk);
    a = x; b = y; op_max = mx;
    @(negedge clk);
    chk(req, res, ref_res(x, y, mx));
    chk("R4", {31'b0, flags[4]}, {31'b0, is_snan(x) || is_snan(y)});
    chk("R5", {28'b0, flags[3:0]}, 32'h0);
  endtask

  task automatic t_reset();
    a = 32'h3F80_0000; b = 32'h7F80_0001; op_max = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset res", res, 32'h0);
    chk("R1 reset flags", {27'b0, flags}, 32'h0);
    rst_n = 1'b1;
  endtask

  task automatic t_select();
    run(32'h3F80_0000, 32'h4000_0000, 1'b0, "R1 min");
    chk("R1 min value", res, 32'h3F80_0000);
    run(32'h3F80_0000, 32'h4000_0000, 1'b1, "R1 max");
    chk("R1 max value", res, 32'h4000_0000);
  endtask

  task automatic t_signs();
    run(32'h0000_0000, 32'h8000_0000, 1'b0, "R6 zero min");
    chk("R6 -0 is min", res, 32'h8000_0000);
    run(32'h8000_0000, 32'h0000_0000, 1'b1, "R6 zero max");
    chk("R6 +0 is max", res, 32'h0000_0000);
    run(32'hC0A0_0000, 32'h4040_0000, 1'b1, "R6 mixed max");
    run(32'hC0A0_0000, 32'h4040_0000, 1'b0, "R6 mixed min");
  endtask

  task automatic t_exp();
    run(32'h4000_0000, 32'h3F80_0000, 1'b0, "R7 pos min");
    run(32'h4000_0000, 32'h3F80_0000, 1'b1, "R7 pos max");
    run(32'hC000_0000, 32'hBF80_0000, 1'b0, "R7 neg min");
    chk("R7 neg min value", res, 32'hC000_0000);
    run(32'h0080_0000, 32'h007F_FFFF, 1'b1, "R7 normal vs subnormal");
  endtask

  task automatic t_man();
    run(32'h3FC0_0000, 32'h3FA0_0000, 1'b0, "R8 pos min");
    run(32'hBFC0_0000, 32'hBFA0_0000, 1'b1, "R8 neg max");
    chk("R8 neg max value", res, 32'hBFA0_0000);
    run(32'h0000_0002, 32'h0000_0001, 1'b1, "R8 subnormal max");
    run(32'h4049_0FDB, 32'h4049_0FDB, 1'b0, "R8 identical");
    chk("R8 identical value", res, 32'h4049_0FDB);
  endtask

  task automatic t_inf();
    run(32'h7F80_0000, 32'h7F7F_FFFF, 1'b1, "R9 +inf max");
    chk("R9 +inf kept", res, 32'h7F80_0000);
    run(32'h7F80_0000, 32'h7F7F_FFFF, 1'b0, "R9 +inf min");
    chk("R9 +inf loses", res, 32'h7F7F_FFFF);
    run(32'hFF7F_FFFF, 32'hFF80_0000, 1'b0, "R9 -inf min");
    run(32'hFF80_0000, 32'h7F80_0000, 1'b1, "R9 inf pair");
  endtask

  task automatic t_nan();
    run(32'h7FC0_0001, 32'h3F80_0000, 1'b0, "R2 qnan a");
    chk("R2 other kept", res, 32'h3F80_0000);
    run(32'hBF80_0000, 32'hFFC0_0000, 1'b1, "R2 qnan b");
    run(32'h7F80_0001, 32'h8000_0000, 1'b1, "R2 snan a with -0");
    chk("R2 -0 passes", res, 32'h8000_0000);
    chk("R4 nv raised", {31'b0, flags[4]}, 32'h1);
    run(32'hFF80_0000, 32'hFFA0_0000, 1'b0, "R2 snan b with -inf");
    run(32'h7F80_0001, 32'hFFC0_0000, 1'b0, "R3 both nan");
    chk("R3 canonical", res, 32'h7FC0_0000);
    run(32'h7FC0_0000, 32'h7FFF_FFFF, 1'b1, "R3 both qnan");
  endtask

  task automatic t_random();
    logic [31:0] pool [12] = '{32'h0000_0000, 32'h8000_0000, 32'h7F80_0000, 32'hFF80_0000,
                               32'h7FC0_0000, 32'h7F80_0001, 32'hFFA0_0000, 32'h0000_0001,
                               32'h807F_FFFF, 32'h3F80_0000, 32'hBF80_0000, 32'h7F7F_FFFF};
    for (int i = 0; i < 1500; i++) begin
      logic [31:0] x, y;
      x = ($urandom % 3 == 0) ? pool[$urandom % 12] : $urandom;
      y = ($urandom % 3 == 0) ? pool[$urandom % 12] : $urandom;
      if (i % 4 == 0) y = {x[31:23], 23'($urandom)};
      run(x, y, 1'($urandom), "R10 random");
    end
  endtask

  initial begin
    t_reset();
    t_select();
    t_signs();
    t_exp();
    t_man();
    t_inf();
    t_nan();
    t_random();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule